// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block decides, once per clock, which resident warp of a multithreaded SIMT core sends its next instruction to the lanes. Each warp slot holds a program counter, a valid flag, a one-entry instruction holding register and a row of pending-destination bits. Each cycle the block fetches at most one instruction, for a live warp whose holding register is empty. It also issues at most one buffered instruction, from a warp whose operands are clear for the warp as a whole. Latency is hidden by switching between warps rather than by forwarding.

The issued instruction, its warp number and its program counter leave the block together as one broadcast to every lane. Software-visible work enters through a launch port, which places a start address into the lowest free slot, and a retire port, which frees a slot. The register file reports completed writes through a writeback tag (warp, register). The instruction store answers a fetch request combinationally in the same cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is live: `iss_valid` and `fetch_valid` are low, `launch_ready` is high and `launch_slot` is 0.
- R2: A launch is accepted when `launch_valid` and `launch_ready` are both high. It takes the lowest-numbered free slot, shown on `launch_slot`, and loads `launch_pc` as that warp's program counter. `launch_ready` is low exactly when every slot is occupied.
- R3: At most one fetch is made per cycle, and only for a live warp whose holding register is empty. `fetch_pc` equals that warp's current program counter, and the returned `fetch_instr` is captured at the next clock edge.
- R4: At most one instruction issues per cycle. `iss_warp`, `iss_pc` and `iss_instr` all describe the same buffered instruction. Each issue advances that warp's program counter by one, wrapping modulo 2^PC_W.
- R5: Instruction fields: destination register in bits [REG_W-1:0], source A in [2*REG_W-1:REG_W], source B in [3*REG_W-1:2*REG_W], and the write flag in bit 3*REG_W. A buffered instruction may not issue while source A or source B is pending for its warp. If the write flag is set, it also may not issue while its destination is pending.
- R6: Issuing an instruction with the write flag set marks its destination register pending for that warp from the next cycle.
- R7: A writeback (`wb_warp`, `wb_reg`) clears only that one pending bit, effective from the next cycle. A writeback to another register or another warp does not unblock a stalled warp. If the same bit is set by an issue in the same cycle, the set wins.
- R8: When no warp is ready, `iss_valid` is low for that cycle (a bubble).
- R9: Among ready warps, selection is round robin, starting with the warp after the one issued last. Warps with equal, hazard-free load receive equal shares of issue slots.
- R10: Retiring a live warp clears its valid flag and its holding register. It is then neither fetched nor issued, and its slot becomes free for launch.
- R11: A launch clears the whole pending row of the slot it takes, so stale marks left by a retired warp never block its successor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Request to start a warp |
| launch_pc | input | PC_W | Start address of the new warp |
| launch_ready | output | 1 | At least one slot is free |
| launch_slot | output | WID_W | Slot the next launch will take |
| retire_valid | input | 1 | Request to end a warp |
| retire_warp | input | WID_W | Warp to end |
| fetch_valid | output | 1 | Fetch request this cycle |
| fetch_warp | output | WID_W | Warp being fetched |
| fetch_pc | output | PC_W | Address being fetched |
| fetch_instr | input | INSTR_W | Instruction returned for `fetch_pc` in the same cycle |
| wb_valid | input | 1 | Register writeback completed |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | REG_W | Register of the writeback |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_warp | output | WID_W | Warp of the issued instruction |
| iss_pc | output | PC_W | Address of the issued instruction |
| iss_instr | output | INSTR_W | Issued instruction broadcast to all lanes |

## Verification
The assertions check the per-cycle properties on every cycle:
- a grant always goes to a requesting warp, and the issue line idles only when nothing is ready;
- fetches only hit empty holding registers and issues only drain full ones;
- each issue steps the program counter;
- pending bits set, clear and wipe as stated;
- no issued instruction carries an operand hazard.

The following are visible only through the bench's scenarios:
- fairness of the rotation over a long run;
- exact stall and release timing around writebacks, including a set and a clear of the same bit in one cycle;
- that retirement empties the core;
- that a relaunched slot ignores stale pending marks.

// File: rtl/warp_sched_pkg.sv
`timescale 1ns/1ps
package warp_sched_pkg;

   // Index width for a count of n items, never below one bit.
   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // True when n is a power of two and at least two.
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/warp_rr_arbiter.sv
`timescale 1ns/1ps
module warp_rr_arbiter
   import warp_sched_pkg::*;
#(
   parameter int N = 64,
   localparam int IW = idx_bits(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);

   logic [IW-1:0] last_q;

   // Search starts one past the last winner; nearest hit wins.
   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = last_q;
      for (int k = N; k >= 1; k--) begin
         int s;
         s = int'(last_q) + k;
         if (s >= N) s = s - N;
         if (req[s]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IW'(s);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         last_q <= IW'(N - 1);
      else if (gnt_valid) last_q <= gnt_idx;
   end

   assert_grant_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> req[gnt_idx]);

   assert_idle_only_without_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> gnt_valid);

   assert_pointer_follows_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |=> (last_q == $past(gnt_idx)));

endmodule

// File: rtl/warp_scoreboard.sv
`timescale 1ns/1ps
module warp_scoreboard
   import warp_sched_pkg::*;
#(
   parameter int NUM_WARPS = 64,
   parameter int REG_W     = 5,
   localparam int NUM_REGS = 1 << REG_W,
   localparam int WID_W    = idx_bits(NUM_WARPS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                set_en,
   input  logic [WID_W-1:0]                    set_warp,
   input  logic [REG_W-1:0]                    set_reg,
   input  logic                                clr_en,
   input  logic [WID_W-1:0]                    clr_warp,
   input  logic [REG_W-1:0]                    clr_reg,
   input  logic                                wipe_en,
   input  logic [WID_W-1:0]                    wipe_warp,
   output logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend
);

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_row
      logic [NUM_REGS-1:0] set_mask, clr_mask;

      assign set_mask = (set_en && set_warp == WID_W'(w)) ? (NUM_REGS'(1) << set_reg) : '0;
      assign clr_mask = (clr_en && clr_warp == WID_W'(w)) ? (NUM_REGS'(1) << clr_reg) : '0;

      // Set beats clear on the same bit; a wipe beats both.
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend[w] <= '0;
         else if (wipe_en && wipe_warp == WID_W'(w))
            pend[w] <= '0;
         else
            pend[w] <= (pend[w] & ~clr_mask) | set_mask;
      end
   end

   // Registered copies of the update addresses, used by the checks below.
   logic [WID_W-1:0] set_w_q, clr_w_q, wipe_w_q;
   logic [REG_W-1:0] set_r_q, clr_r_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_w_q  <= '0;
         set_r_q  <= '0;
         clr_w_q  <= '0;
         clr_r_q  <= '0;
         wipe_w_q <= '0;
      end else begin
         set_w_q  <= set_warp;
         set_r_q  <= set_reg;
         clr_w_q  <= clr_warp;
         clr_r_q  <= clr_reg;
         wipe_w_q <= wipe_warp;
      end
   end

   logic clr_alone;
   assign clr_alone = clr_en && !(set_en && set_warp == clr_warp && set_reg == clr_reg)
                      && !(wipe_en && wipe_warp == clr_warp);

   assert_issue_marks_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !(wipe_en && wipe_warp == set_warp)) |=> pend[set_w_q][set_r_q]);

   assert_writeback_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_alone |=> !pend[clr_w_q][clr_r_q]);

   assert_launch_wipes_row_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wipe_en |=> (pend[wipe_w_q] == '0));

endmodule

// File: rtl/warp_context.sv
`timescale 1ns/1ps
module warp_context #(
   parameter int PC_W    = 32,
   parameter int INSTR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch_en,
   input  logic [PC_W-1:0]    launch_pc,
   input  logic               retire_en,
   input  logic               fetch_en,
   input  logic [INSTR_W-1:0] fetch_instr,
   input  logic               issue_en,
   output logic               valid,
   output logic               buf_full,
   output logic [PC_W-1:0]    pc,
   output logic [INSTR_W-1:0] instr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         buf_full <= 1'b0;
         pc       <= '0;
         instr    <= '0;
      end else if (retire_en) begin
         valid    <= 1'b0;
         buf_full <= 1'b0;
      end else if (launch_en) begin
         valid    <= 1'b1;
         buf_full <= 1'b0;
         pc       <= launch_pc;
      end else begin
         if (fetch_en) begin
            buf_full <= 1'b1;
            instr    <= fetch_instr;
         end
         if (issue_en) begin
            buf_full <= 1'b0;
            pc       <= pc + 1'b1;
         end
      end
   end

   assert_fetch_into_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |-> (valid && !buf_full));

   assert_issue_from_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_en |-> (valid && buf_full));

   assert_pc_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_en && !retire_en) |=> (pc == $past(pc) + 1'b1));

   assert_retire_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      retire_en |=> (!valid && !buf_full));

   assert_launch_loads_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_en && !retire_en) |=> (valid && pc == $past(launch_pc)));

endmodule

// File: rtl/warp_issue_sched.sv
`timescale 1ns/1ps
module warp_issue_sched
   import warp_sched_pkg::*;
#(
   parameter int NUM_WARPS = 64,
   parameter int REG_W     = 5,
   parameter int PC_W      = 32,
   parameter int INSTR_W   = 32,
   localparam int WID_W    = idx_bits(NUM_WARPS),
   localparam int NUM_REGS = 1 << REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch_valid,
   input  logic [PC_W-1:0]    launch_pc,
   output logic               launch_ready,
   output logic [WID_W-1:0]   launch_slot,
   input  logic               retire_valid,
   input  logic [WID_W-1:0]   retire_warp,
   output logic               fetch_valid,
   output logic [WID_W-1:0]   fetch_warp,
   output logic [PC_W-1:0]    fetch_pc,
   input  logic [INSTR_W-1:0] fetch_instr,
   input  logic               wb_valid,
   input  logic [WID_W-1:0]   wb_warp,
   input  logic [REG_W-1:0]   wb_reg,
   output logic               iss_valid,
   output logic [WID_W-1:0]   iss_warp,
   output logic [PC_W-1:0]    iss_pc,
   output logic [INSTR_W-1:0] iss_instr
);

   localparam int WR_BIT = 3 * REG_W;

   if (INSTR_W < WR_BIT + 1) begin : g_bad_instr_w
      $error("INSTR_W too small for the operand fields");
   end
   if (!is_pow2(NUM_WARPS)) begin : g_bad_warps
      $error("NUM_WARPS must be a power of two, at least 2");
   end
   if (PC_W < 1 || REG_W < 1) begin : g_bad_widths
      $error("PC_W and REG_W must be positive");
   end

   logic [NUM_WARPS-1:0]               valid_vec, full_vec, ready_vec, fetch_req;
   logic [PC_W-1:0]                    pc_arr    [NUM_WARPS];
   logic [INSTR_W-1:0]                 instr_arr [NUM_WARPS];
   logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend;
   logic                               launch_fire;

   // Lowest free slot takes the next launch.
   always_comb begin
      launch_slot = '0;
      for (int w = NUM_WARPS - 1; w >= 0; w--) begin
         if (!valid_vec[w]) launch_slot = WID_W'(w);
      end
   end
   assign launch_ready = ~&valid_vec;
   assign launch_fire  = launch_valid && launch_ready;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [REG_W-1:0] f_dst, f_sa, f_sb;
      logic             f_wr;

      warp_context #(
         .PC_W    (PC_W),
         .INSTR_W (INSTR_W)
      ) u_ctx (
         .clk         (clk),
         .rst_n       (rst_n),
         .launch_en   (launch_fire && launch_slot == WID_W'(w)),
         .launch_pc   (launch_pc),
         .retire_en   (retire_valid && retire_warp == WID_W'(w) && valid_vec[w]),
         .fetch_en    (fetch_valid && fetch_warp == WID_W'(w)),
         .fetch_instr (fetch_instr),
         .issue_en    (iss_valid && iss_warp == WID_W'(w)),
         .valid       (valid_vec[w]),
         .buf_full    (full_vec[w]),
         .pc          (pc_arr[w]),
         .instr       (instr_arr[w])
      );

      assign f_dst = instr_arr[w][REG_W-1:0];
      assign f_sa  = instr_arr[w][2*REG_W-1:REG_W];
      assign f_sb  = instr_arr[w][3*REG_W-1:2*REG_W];
      assign f_wr  = instr_arr[w][WR_BIT];

      // Whole-warp readiness: one scoreboard row gates every lane.
      assign ready_vec[w] = valid_vec[w] && full_vec[w]
                            && !pend[w][f_sa] && !pend[w][f_sb]
                            && !(f_wr && pend[w][f_dst]);
      assign fetch_req[w] = valid_vec[w] && !full_vec[w];
   end

   warp_rr_arbiter #(.N(NUM_WARPS)) u_fetch_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (fetch_req),
      .gnt_valid (fetch_valid),
      .gnt_idx   (fetch_warp)
   );

   warp_rr_arbiter #(.N(NUM_WARPS)) u_issue_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (ready_vec),
      .gnt_valid (iss_valid),
      .gnt_idx   (iss_warp)
   );

   assign fetch_pc  = pc_arr[fetch_warp];
   assign iss_pc    = pc_arr[iss_warp];
   assign iss_instr = instr_arr[iss_warp];

   warp_scoreboard #(
      .NUM_WARPS (NUM_WARPS),
      .REG_W     (REG_W)
   ) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (iss_valid && iss_instr[WR_BIT]),
      .set_warp  (iss_warp),
      .set_reg   (iss_instr[REG_W-1:0]),
      .clr_en    (wb_valid),
      .clr_warp  (wb_warp),
      .clr_reg   (wb_reg),
      .wipe_en   (launch_fire),
      .wipe_warp (launch_slot),
      .pend      (pend)
   );

   assert_launch_into_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_fire |-> !valid_vec[launch_slot]);

   assert_issue_hazard_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (!pend[iss_warp][iss_instr[2*REG_W-1:REG_W]]
                     && !pend[iss_warp][iss_instr[3*REG_W-1:2*REG_W]]
                     && !(iss_instr[WR_BIT] && pend[iss_warp][iss_instr[REG_W-1:0]])));

   assert_fetch_target_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (valid_vec[fetch_warp] && !full_vec[fetch_warp]));

endmodule

// File: tb/warp_issue_sched_bench.sv
`timescale 1ns/1ps
module warp_issue_sched_bench;

   localparam int NW = 4;
   localparam int RW = 3;
   localparam int PW = 8;
   localparam int IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          launch_valid = 1'b0;
   logic [PW-1:0] launch_pc = '0;
   logic          launch_ready;
   logic [1:0]    launch_slot;
   logic          retire_valid = 1'b0;
   logic [1:0]    retire_warp = '0;
   logic          fetch_valid;
   logic [1:0]    fetch_warp;
   logic [PW-1:0] fetch_pc;
   logic [IW-1:0] fetch_instr;
   logic          wb_valid = 1'b0;
   logic [1:0]    wb_warp = '0;
   logic [RW-1:0] wb_reg = '0;
   logic          iss_valid;
   logic [1:0]    iss_warp;
   logic [PW-1:0] iss_pc;
   logic [IW-1:0] iss_instr;

   logic [IW-1:0] prog [NW][16];
   assign fetch_instr = prog[fetch_warp][fetch_pc[3:0]];

   always #2.5 clk = ~clk;

   warp_issue_sched #(
      .NUM_WARPS (NW),
      .REG_W     (RW),
      .PC_W      (PW),
      .INSTR_W   (IW)
   ) u_warp_issue_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_valid (launch_valid),
      .launch_pc    (launch_pc),
      .launch_ready (launch_ready),
      .launch_slot  (launch_slot),
      .retire_valid (retire_valid),
      .retire_warp  (retire_warp),
      .fetch_valid  (fetch_valid),
      .fetch_warp   (fetch_warp),
      .fetch_pc     (fetch_pc),
      .fetch_instr  (fetch_instr),
      .wb_valid     (wb_valid),
      .wb_warp      (wb_warp),
      .wb_reg       (wb_reg),
      .iss_valid    (iss_valid),
      .iss_warp     (iss_warp),
      .iss_pc       (iss_pc),
      .iss_instr    (iss_instr)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // Issue monitor for the long hazard-free run.
   bit            mon_en = 1'b0;
   int            mon_total = 0;
   int            mon_bad = 0;
   int            mon_cnt [NW];
   logic [PW-1:0] exp_pc [NW];

   always @(negedge clk) begin
      if (mon_en && iss_valid) begin
         mon_total++;
         mon_cnt[iss_warp]++;
         if (iss_pc != exp_pc[iss_warp] || iss_instr != prog[iss_warp][iss_pc[3:0]])
            mon_bad++;
         exp_pc[iss_warp] = exp_pc[iss_warp] + 1'b1;
      end
   end

   // Encoding per R5: {write, srcB, srcA, dst} in the low 10 bits.
   function automatic logic [IW-1:0] mk(input bit wr, input int d, input int a, input int b);
      return IW'({wr, 3'(b), 3'(a), 3'(d)});
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_launch(input logic [PW-1:0] pc);
      launch_valid = 1'b1;
      launch_pc    = pc;
      tick();
      launch_valid = 1'b0;
   endtask

   task automatic do_retire(input int w);
      retire_valid = 1'b1;
      retire_warp  = 2'(w);
      tick();
      retire_valid = 1'b0;
   endtask

   task automatic do_wb(input int w, input int r);
      wb_valid = 1'b1;
      wb_warp  = 2'(w);
      wb_reg   = RW'(r);
      tick();
      wb_valid = 1'b0;
   endtask

   task automatic wait_issue();
      for (int i = 0; i < 8; i++) begin
         if (iss_valid) break;
         tick();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < NW; w++) begin
         mon_cnt[w] = 0;
         for (int i = 0; i < 16; i++)
            prog[w][i] = IW'((w * 16 + i) * 37) & ~IW'(16'h0200);
      end

      repeat (3) tick();
      rst_n = 1'b1;

      // R1 reset state
      chk(!iss_valid, "R1", "iss_valid", iss_valid, 0);
      chk(!fetch_valid, "R1", "fetch_valid", fetch_valid, 0);
      chk(launch_ready && launch_slot == 0, "R1", "launch_slot", launch_slot, 0);

      // R2 launches fill slots lowest first; R4/R9 long hazard-free run
      exp_pc[0] = 8'h00; exp_pc[1] = 8'h40; exp_pc[2] = 8'h80; exp_pc[3] = 8'hF0;
      mon_en = 1'b1;
      for (int w = 0; w < NW; w++) begin
         chk(launch_slot == 2'(w), "R2", "launch_slot", launch_slot, w);
         do_launch(exp_pc[w]);
      end
      chk(!launch_ready, "R2", "launch_ready when full", launch_ready, 0);
      repeat (200) tick();
      mon_en = 1'b0;
      chk(mon_bad == 0, "R4", "pc/instr mismatches", mon_bad, 0);
      chk(mon_total >= 190, "R4", "issues in run", mon_total, 190);
      begin
         int mn, mx;
         mn = mon_cnt[0];
         mx = mon_cnt[0];
         for (int w = 1; w < NW; w++) begin
            if (mon_cnt[w] < mn) mn = mon_cnt[w];
            if (mon_cnt[w] > mx) mx = mon_cnt[w];
         end
         chk(mx - mn <= 2, "R9", "share spread", mx - mn, 2);
      end

      // R10 retire all warps
      for (int w = 0; w < NW; w++) do_retire(w);
      tick();
      tick();
      chk(!iss_valid, "R10", "iss_valid after retire", iss_valid, 0);
      chk(!fetch_valid, "R10", "fetch_valid after retire", fetch_valid, 0);
      chk(launch_ready && launch_slot == 0, "R10", "free slot", launch_slot, 0);
      chk(!iss_valid, "R8", "bubble with no warp", iss_valid, 0);

      // Scoreboard program for warp 0
      for (int i = 0; i < 16; i++) prog[0][i] = '0;
      prog[0][0] = mk(1, 2, 0, 0);
      prog[0][1] = mk(0, 0, 2, 0);
      prog[0][2] = mk(1, 5, 0, 0);
      prog[0][3] = mk(1, 5, 0, 0);
      prog[0][4] = mk(0, 0, 0, 5);
      prog[0][5] = mk(1, 6, 0, 0);
      prog[0][8] = mk(0, 0, 6, 0);

      do_launch(8'h00);
      chk(fetch_valid && fetch_warp == 0 && fetch_pc == 0, "R3", "fetch_pc", fetch_pc, 0);
      tick();
      chk(iss_valid && iss_pc == 0 && iss_warp == 0, "R4", "first issue pc", iss_pc, 0);
      chk(iss_instr == prog[0][0], "R4", "broadcast instr", iss_instr, prog[0][0]);
      tick();
      chk(fetch_valid && fetch_pc == 1, "R3", "fetch after issue", fetch_pc, 1);
      tick();
      chk(!iss_valid, "R5", "srcA hazard stall", iss_valid, 0);
      repeat (3) tick();
      chk(!iss_valid, "R8", "bubble while stalled", iss_valid, 0);
      chk(!fetch_valid, "R3", "no fetch into full register", fetch_valid, 0);
      do_wb(0, 3);
      chk(!iss_valid, "R7", "other register writeback", iss_valid, 0);
      do_wb(1, 2);
      chk(!iss_valid, "R7", "other warp writeback", iss_valid, 0);
      do_wb(0, 2);
      chk(iss_valid && iss_pc == 1, "R7", "release after writeback", iss_pc, 1);
      tick();
      wait_issue();
      chk(iss_valid && iss_pc == 2, "R4", "next issue pc", iss_pc, 2);
      tick();
      repeat (4) tick();
      chk(!iss_valid, "R6", "destination pending blocks rewrite", iss_valid, 0);
      do_wb(0, 5);
      chk(iss_valid && iss_pc == 3, "R7", "release of r5", iss_pc, 3);
      do_wb(0, 5);
      repeat (3) tick();
      chk(!iss_valid, "R7", "set wins over same-cycle clear (srcB stall)", iss_valid, 0);
      do_wb(0, 5);
      chk(iss_valid && iss_pc == 4, "R5", "srcB release", iss_pc, 4);
      repeat (14) tick();
      chk(!iss_valid, "R5", "stall on r6 at pc 8", iss_valid, 0);

      // R11 relaunch ignores stale pending r6
      do_retire(0);
      tick();
      chk(!iss_valid && launch_slot == 0, "R10", "slot 0 free", launch_slot, 0);
      do_launch(8'h08);
      tick();
      chk(iss_valid && iss_pc == 8, "R11", "relaunched warp not blocked", iss_pc, 8);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule